// File: doc/BRIEF.md
# Flash In-Application Programming Controller

This block sequences byte program, bank erase, whole-array erase and byte read-back on a two-bank on-chip flash for an 8-bit CPU. Software drives it through a small register mailbox: it loads a 16-bit address, a data byte and a configuration byte, then writes a command code. Writing the command register is the only event that ever starts anything. A status register reports busy, done and a sticky rejection flag.

The bank an operation lands on is never chosen freely. Code running from one internal bank always targets the other bank, so a bank can never rewrite itself. Code running from external program space picks its bank from the address and a bank-select state: bank 1 may be overlaid on the lowest 8 KB of the 64 KB window. Per-bank lock levels can refuse a command. The whole-array erase has its own rules. Program and erase lengths are modelled by a cycle countdown, and a timing-oscillator enable is raised only for that countdown. A small behavioural array model holds the cell contents, so that program and erase results can be read back.

Top module: `flash_iap_ctrl`

## Requirements
- R1: Register map by `reg_addr`: 0 status (read only, bit0 busy, bit1 reject, bit2 done, other bits 0), 1 command (reads 0), 2 address low, 3 address high, 4 data, 5 configuration; 6 and 7 read 0. All registers reset to 0, and a register write takes effect on the clock edge where `reg_wr` is sampled.
- R2: Configuration bit 6 enables commands. While it is 0, a command write starts nothing and sets neither busy nor reject; it does still clear reject and done.
- R3: Fetch source encoding is 00 bank 0, 01 bank 1, 1x external. From bank 0 the target is bank 1, and from bank 1 the target is bank 0, whatever the address.
- R4: From external space, the overlay is on when configuration bits [1:0] are 01, follows `ea_pin` (1 = on) when they are 00, and is off when they are 1x. The target is bank 1 when the overlay is on and address bits [15:13] are 0; otherwise it is bank 0. The cell index is address bits [AW-1:0].
- R5: Program, erase or read on a target whose lock level is nonzero is refused: reject is set and no operation starts. Every command write clears reject and done.
- R6: Chip erase (code 44h) is accepted only from external space and only when neither lock level equals 4. It ignores lower lock levels, erases both banks, and pulses `sec_clr` high for one cycle right after it completes.
- R7: Busy and `osc_en` are high for exactly PROG_CYC (default 4), ERASE_CYC (12) or CHIP_CYC (20) cycles after an accepted program (22h), bank erase (33h) or chip erase command. `fl_prog`, `fl_erase` and `fl_chip` are high only during their own operation, and `fl_bank`, `fl_addr` and `fl_wdata` are held stable for its whole length.
- R8: A program stores the AND of the old cell and the data register. An erase sets every cell of the target bank to FFh. A read command (11h) copies the target cell into the data register on the same edge, sets done, and never raises busy.
- R9: While busy, every register write is ignored, including a write on the edge that completes the operation. Done is set when an operation completes.
- R10: Any other command code, with commands enabled, sets reject and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| fetch_src | input | 2 | Where the issuing code runs: 00 bank 0, 01 bank 1, 1x external |
| ea_pin | input | 1 | External-access pin level used by the bank-select state |
| lock_lvl0 | input | 3 | Lock level of bank 0 (0 = unlocked, 4 = highest) |
| lock_lvl1 | input | 3 | Lock level of bank 1 |
| fl_bank | output | 1 | Target bank of the running operation |
| fl_addr | output | 16 | Operation address |
| fl_wdata | output | 8 | Program data |
| fl_prog | output | 1 | Byte program in progress |
| fl_erase | output | 1 | Bank erase in progress |
| fl_chip | output | 1 | Whole-array erase in progress |
| sec_clr | output | 1 | One-cycle pulse that clears the lock and remap bits after a chip erase |
| osc_en | output | 1 | Timing oscillator enable |

## Verification
Two events can meet on one edge: the countdown reaching its end, and a register write from the CPU. The bench lands a configuration write exactly on the completion edge of a bank erase by counting edges from the command write. The expected outcome is that done rises while the configuration keeps its old value, because busy was still high when the write was sampled. A behavioural reference model sees the same coincidence and is compared on every cycle, and a read-back of the configuration register afterwards gives the outcome at the ports.

// File: rtl/iap_pkg.sv
package iap_pkg;
    localparam logic [2:0] RA_STAT = 3'd0;
    localparam logic [2:0] RA_CMD  = 3'd1;
    localparam logic [2:0] RA_ADL  = 3'd2;
    localparam logic [2:0] RA_ADH  = 3'd3;
    localparam logic [2:0] RA_DAT  = 3'd4;
    localparam logic [2:0] RA_CFG  = 3'd5;

    localparam logic [7:0] CMD_READ  = 8'h11;
    localparam logic [7:0] CMD_PROG  = 8'h22;
    localparam logic [7:0] CMD_ERASE = 8'h33;
    localparam logic [7:0] CMD_CHIP  = 8'h44;

    localparam int         CFG_EN_BIT = 6;
    localparam logic [2:0] LOCK_TOP   = 3'd4;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_CHIP  = 2'd3
    } op_e;
endpackage

// File: rtl/iap_target.sv
module iap_target (
    input  logic [1:0] fetch_src,
    input  logic       ea_pin,
    input  logic [1:0] bank_sel,
    input  logic [2:0] addr_top,
    input  logic [2:0] lock0,
    input  logic [2:0] lock1,
    output logic       tgt_bank,
    output logic       tgt_locked,
    output logic       chip_ok
);
    import iap_pkg::*;

    logic overlay;
    logic src_ext;

    always_comb begin
        src_ext = fetch_src[1];
        unique case (bank_sel)
            2'b00:   overlay = ea_pin;
            2'b01:   overlay = 1'b1;
            default: overlay = 1'b0;
        endcase
        if (src_ext) begin
            tgt_bank = overlay && (addr_top == 3'd0);
        end else begin
            tgt_bank = ~fetch_src[0];
        end
        tgt_locked = tgt_bank ? (lock1 != 3'd0) : (lock0 != 3'd0);
        chip_ok    = src_ext && (lock0 != LOCK_TOP) && (lock1 != LOCK_TOP);
    end
endmodule

// File: rtl/iap_seq.sv
module iap_seq #(
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 12,
    parameter int CHIP_CYC  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  iap_pkg::op_e  start_op,
    output logic          busy,
    output logic          last,
    output iap_pkg::op_e  op
);
    import iap_pkg::*;

    localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_C = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
    localparam int CW    = $clog2(MAX_C + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        op_e           op;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.op = start_op;
            unique case (start_op)
                OP_PROG:  seq_d.cnt = CW'(PROG_CYC);
                OP_ERASE: seq_d.cnt = CW'(ERASE_CYC);
                OP_CHIP:  seq_d.cnt = CW'(CHIP_CYC);
                default:  seq_d.cnt = CW'(0);
            endcase
        end else if (seq_q.cnt != '0) begin
            seq_d.cnt = seq_q.cnt - CW'(1);
            if (seq_q.cnt == CW'(1)) begin
                seq_d.op = OP_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{cnt: '0, op: OP_NONE};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.cnt != '0);
    assign last = (seq_q.cnt == CW'(1));
    assign op   = seq_q.op;

    // R7
    end_of_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);

    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && $stable(op)));

    // R9
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/iap_array.sv
module iap_array #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  iap_pkg::op_e  op,
    input  logic          bank,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data
);
    import iap_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic [7:0] bank_rd [2];

    for (genvar gb = 0; gb < 2; gb++) begin : g_bank
        logic [7:0] cells [DEPTH];
        logic       mine;

        assign mine = (bank == gb[0]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
            end else if (commit) begin
                if ((op == OP_CHIP) || ((op == OP_ERASE) && mine)) begin
                    for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
                end else if ((op == OP_PROG) && mine) begin
                    cells[idx] <= cells[idx] & wdata;
                end
            end
        end

        assign bank_rd[gb] = cells[rd_idx];
    end

    assign rd_data = rd_bank ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/flash_iap_ctrl.sv
module flash_iap_ctrl #(
    parameter int AW        = 6,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 12,
    parameter int CHIP_CYC  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [1:0]  fetch_src,
    input  logic        ea_pin,
    input  logic [2:0]  lock_lvl0,
    input  logic [2:0]  lock_lvl1,
    output logic        fl_bank,
    output logic [15:0] fl_addr,
    output logic [7:0]  fl_wdata,
    output logic        fl_prog,
    output logic        fl_erase,
    output logic        fl_chip,
    output logic        sec_clr,
    output logic        osc_en
);
    import iap_pkg::*;

    typedef struct packed {
        logic [7:0] cfg;
        logic [7:0] adl;
        logic [7:0] adh;
        logic [7:0] dat;
        logic       rej;
        logic       done;
        logic       bank;
        logic       secc;
    } regs_s;

    regs_s r_d, r_q;

    logic        busy, last;
    op_e         cur_op;
    logic        start;
    op_e         start_op;
    logic        tgt_bank, tgt_locked, chip_ok;
    logic [15:0] addr_w;
    logic [7:0]  rd_data;
    logic        cmd_wr;

    assign addr_w = {r_q.adh, r_q.adl};

    iap_target u_target (
        .fetch_src  (fetch_src),
        .ea_pin     (ea_pin),
        .bank_sel   (r_q.cfg[1:0]),
        .addr_top   (r_q.adh[7:5]),
        .lock0      (lock_lvl0),
        .lock1      (lock_lvl1),
        .tgt_bank   (tgt_bank),
        .tgt_locked (tgt_locked),
        .chip_ok    (chip_ok)
    );

    iap_seq #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .CHIP_CYC  (CHIP_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_op (start_op),
        .busy     (busy),
        .last     (last),
        .op       (cur_op)
    );

    iap_array #(.AW(AW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (last),
        .op      (cur_op),
        .bank    (r_q.bank),
        .idx     (addr_w[AW-1:0]),
        .wdata   (r_q.dat),
        .rd_bank (tgt_bank),
        .rd_idx  (addr_w[AW-1:0]),
        .rd_data (rd_data)
    );

    assign cmd_wr = reg_wr && !busy && (reg_addr == RA_CMD);

    always_comb begin
        r_d      = r_q;
        start    = 1'b0;
        start_op = OP_NONE;
        r_d.secc = 1'b0;
        if (last) begin
            r_d.done = 1'b1;
            r_d.secc = (cur_op == OP_CHIP);
        end
        if (reg_wr && !busy) begin
            unique case (reg_addr)
                RA_ADL: r_d.adl = reg_wdata;
                RA_ADH: r_d.adh = reg_wdata;
                RA_DAT: r_d.dat = reg_wdata;
                RA_CFG: r_d.cfg = reg_wdata;
                RA_CMD: begin
                    r_d.rej  = 1'b0;
                    r_d.done = 1'b0;
                    if (r_q.cfg[CFG_EN_BIT]) begin
                        unique case (reg_wdata)
                            CMD_READ: begin
                                if (tgt_locked) begin
                                    r_d.rej = 1'b1;
                                end else begin
                                    r_d.dat  = rd_data;
                                    r_d.done = 1'b1;
                                end
                            end
                            CMD_PROG, CMD_ERASE: begin
                                if (tgt_locked) begin
                                    r_d.rej = 1'b1;
                                end else begin
                                    start    = 1'b1;
                                    start_op = (reg_wdata == CMD_PROG) ? OP_PROG : OP_ERASE;
                                    r_d.bank = tgt_bank;
                                end
                            end
                            CMD_CHIP: begin
                                if (!chip_ok) begin
                                    r_d.rej = 1'b1;
                                end else begin
                                    start    = 1'b1;
                                    start_op = OP_CHIP;
                                    r_d.bank = 1'b0;
                                end
                            end
                            default: r_d.rej = 1'b1;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_STAT: reg_rdata = {5'b0, r_q.done, r_q.rej, busy};
            RA_ADL:  reg_rdata = r_q.adl;
            RA_ADH:  reg_rdata = r_q.adh;
            RA_DAT:  reg_rdata = r_q.dat;
            RA_CFG:  reg_rdata = r_q.cfg;
            default: reg_rdata = 8'h00;
        endcase
    end

    assign fl_bank  = r_q.bank;
    assign fl_addr  = addr_w;
    assign fl_wdata = r_q.dat;
    assign fl_prog  = busy && (cur_op == OP_PROG);
    assign fl_erase = busy && (cur_op == OP_ERASE);
    assign fl_chip  = busy && (cur_op == OP_CHIP);
    assign sec_clr  = r_q.secc;
    assign osc_en   = busy;

    // R2
    enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !r_q.cfg[CFG_EN_BIT]) |=> (!busy && !r_q.rej));

    // R3
    self_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && (cur_op != OP_CHIP) && !$past(fetch_src[1]))
        |-> (fl_bank != $past(fetch_src[0])));

    // R6
    chip_from_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_chip) |-> $past(fetch_src[1]));

    // R9
    busy_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> ($stable(r_q.cfg) && $stable(r_q.adl) && $stable(r_q.dat)));

    // R5
    lock_refusal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && r_q.cfg[CFG_EN_BIT] && tgt_locked && (reg_wdata != CMD_CHIP))
        |=> (r_q.rej && !busy));
endmodule

// File: tb/tb_flash_iap_ctrl.sv
`timescale 1ns/1ps
module tb_flash_iap_ctrl;
    localparam int AW = 6;
    localparam int NC = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [1:0]  fetch_src = 2'b00;
    logic        ea_pin = 1'b0;
    logic [2:0]  lock_lvl0 = 3'd0;
    logic [2:0]  lock_lvl1 = 3'd0;
    logic        fl_bank;
    logic [15:0] fl_addr;
    logic [7:0]  fl_wdata;
    logic        fl_prog, fl_erase, fl_chip, sec_clr, osc_en;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    always #2 clk = ~clk;

    flash_iap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_src(fetch_src),
        .ea_pin(ea_pin), .lock_lvl0(lock_lvl0), .lock_lvl1(lock_lvl1),
        .fl_bank(fl_bank), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_prog(fl_prog), .fl_erase(fl_erase), .fl_chip(fl_chip),
        .sec_clr(sec_clr), .osc_en(osc_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_cnt, m_op;          // op: 1 prog, 2 erase, 3 chip
    bit         m_bank, m_rej, m_done, m_sec;
    logic [7:0] m_cfg, m_adl, m_adh, m_dat;
    logic [7:0] m_mem [2][NC];

    function automatic bit m_target();
        bit ovl;
        if (fetch_src[1]) begin
            ovl = m_cfg[1] ? 1'b0 : (m_cfg[0] ? 1'b1 : ea_pin);
            return ovl && (m_adh[7:5] == 3'd0);
        end
        return !fetch_src[0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_op = 0; m_bank = 0; m_rej = 0; m_done = 0; m_sec = 0;
            m_cfg = 0; m_adl = 0; m_adh = 0; m_dat = 0;
            for (int b = 0; b < 2; b++) for (int i = 0; i < NC; i++) m_mem[b][i] = 8'hFF;
        end else begin
            int idx;
            bit t, lk;
            idx = m_adl[AW-1:0];
            m_sec = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1;
                    if (m_op == 1) m_mem[m_bank][idx] = m_mem[m_bank][idx] & m_dat;
                    if (m_op == 2) for (int i = 0; i < NC; i++) m_mem[m_bank][i] = 8'hFF;
                    if (m_op == 3) begin
                        for (int b = 0; b < 2; b++) for (int i = 0; i < NC; i++) m_mem[b][i] = 8'hFF;
                        m_sec = 1;
                    end
                    m_op = 0;
                end
            end else if (reg_wr) begin
                case (reg_addr)
                    3'd2: m_adl = reg_wdata;
                    3'd3: m_adh = reg_wdata;
                    3'd4: m_dat = reg_wdata;
                    3'd5: m_cfg = reg_wdata;
                    3'd1: begin
                        m_rej = 0; m_done = 0;
                        t  = m_target();
                        lk = t ? (lock_lvl1 != 0) : (lock_lvl0 != 0);
                        if (m_cfg[6]) begin
                            case (reg_wdata)
                                8'h11: if (lk) m_rej = 1; else begin m_dat = m_mem[t][idx]; m_done = 1; end
                                8'h22: if (lk) m_rej = 1; else begin m_op = 1; m_cnt = 4; m_bank = t; end
                                8'h33: if (lk) m_rej = 1; else begin m_op = 2; m_cnt = 12; m_bank = t; end
                                8'h44: if (!fetch_src[1] || lock_lvl0 == 4 || lock_lvl1 == 4) m_rej = 1;
                                       else begin m_op = 3; m_cnt = 20; m_bank = 0; end
                                default: m_rej = 1;
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            logic [7:0] er;
            bit mb;
            mb = (m_cnt > 0);
            case (reg_addr)
                3'd0: er = {5'b0, m_done, m_rej, mb};
                3'd2: er = m_adl;
                3'd3: er = m_adh;
                3'd4: er = m_dat;
                3'd5: er = m_cfg;
                default: er = 8'h00;
            endcase
            chk(reg_rdata == er, "R1 per-cycle register read", reg_rdata, er);
            chk(osc_en == mb, "R7 per-cycle oscillator enable", osc_en, mb);
            chk(fl_prog == (mb && m_op == 1), "R7 per-cycle program strobe", fl_prog, mb && m_op == 1);
            chk(fl_erase == (mb && m_op == 2), "R7 per-cycle erase strobe", fl_erase, mb && m_op == 2);
            chk(fl_chip == (mb && m_op == 3), "R6 per-cycle chip strobe", fl_chip, mb && m_op == 3);
            chk(sec_clr == m_sec, "R6 per-cycle lock clear pulse", sec_clr, m_sec);
            if (mb) begin
                chk(fl_bank == m_bank, "R3 per-cycle target bank", fl_bank, m_bank);
                chk(fl_addr == {m_adh, m_adl}, "R7 per-cycle address", fl_addr, {m_adh, m_adl});
                chk(fl_wdata == m_dat, "R7 per-cycle data", fl_wdata, m_dat);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == exp, tag, reg_rdata, exp);
        @(posedge clk); #1;
        reg_addr = 3'd0;
    endtask

    // Called right after a command write: counts cycles with osc_en high.
    task automatic measure(output int n, output int pulses);
        n = 0; pulses = 0;
        @(negedge clk);
        while (osc_en) begin
            n++;
            if (sec_clr) pulses++;
            @(negedge clk);
        end
        if (sec_clr) pulses++;
        @(negedge clk);
        if (sec_clr) pulses++;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_cnt != 0) @(negedge clk);
    endtask

    initial begin
        int n, p;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        peek(3'd0, 8'h00, "R1 status after reset");
        peek(3'd5, 8'h00, "R1 config after reset");

        // R2: commands disabled
        wr(3'd2, 8'h05); wr(3'd4, 8'h3C);
        wr(3'd1, 8'h22);
        @(negedge clk);
        chk(osc_en == 1'b0, "R2 disabled command started nothing", osc_en, 0);
        peek(3'd0, 8'h00, "R2 status after disabled command");

        // R7, R3: program from bank 0 goes to bank 1
        wr(3'd5, 8'h40);
        fetch_src = 2'b00;
        wr(3'd1, 8'h22);
        chk(fl_bank == 1'b1, "R3 bank0 code targets bank1", fl_bank, 1);
        measure(n, p);
        chk(n == 4, "R7 program length", n, 4);
        wr(3'd1, 8'h11);
        peek(3'd4, 8'h3C, "R8 read back programmed byte");
        peek(3'd0, 8'h04, "R8 read sets done without busy");

        // R8: second program ANDs
        wr(3'd4, 8'hF0); wr(3'd1, 8'h22); wait_idle();
        wr(3'd1, 8'h11);
        peek(3'd4, 8'h30, "R8 program is AND of old and new");

        // R3: bank 1 code targets bank 0 (still erased)
        fetch_src = 2'b01;
        wr(3'd1, 8'h11);
        peek(3'd4, 8'hFF, "R3 bank1 code reads bank0");
        wr(3'd4, 8'h5A); wr(3'd1, 8'h22);
        chk(fl_bank == 1'b0, "R3 bank1 code targets bank0", fl_bank, 0);
        wait_idle();

        // R5: locked target refused, reject sticky, cleared by next command
        fetch_src = 2'b00; lock_lvl1 = 3'd2;
        wr(3'd1, 8'h22);
        @(negedge clk);
        chk(osc_en == 1'b0, "R5 locked target not started", osc_en, 0);
        peek(3'd0, 8'h02, "R5 reject flag set");
        peek(3'd0, 8'h02, "R5 reject flag sticky");
        lock_lvl1 = 3'd0;
        wr(3'd1, 8'h11);
        peek(3'd0, 8'h04, "R5 reject cleared by next command");

        // R4: external bank selection
        fetch_src = 2'b10;
        wr(3'd5, 8'h41); wr(3'd3, 8'h00); wr(3'd1, 8'h11);
        peek(3'd4, 8'h30, "R4 overlay on, low window is bank1");
        wr(3'd3, 8'h20); wr(3'd1, 8'h11);
        peek(3'd4, 8'h5A, "R4 above 8 KB is bank0");
        wr(3'd5, 8'h42); wr(3'd3, 8'h00); wr(3'd1, 8'h11);
        peek(3'd4, 8'h5A, "R4 overlay off gives bank0");
        wr(3'd5, 8'h40); ea_pin = 1'b1; wr(3'd1, 8'h11);
        peek(3'd4, 8'h30, "R4 overlay follows pin high");
        ea_pin = 1'b0; wr(3'd1, 8'h11);
        peek(3'd4, 8'h5A, "R4 overlay follows pin low");

        // R9: erase bank1, config write landing on the completion edge
        fetch_src = 2'b00;
        wr(3'd1, 8'h33);
        wr(3'd2, 8'h09);                       // ignored while busy
        repeat (8) @(posedge clk);
        wr(3'd5, 8'h00);                       // lands on completion edge
        peek(3'd5, 8'h40, "R9 write on completion edge ignored");
        peek(3'd2, 8'h05, "R9 address write while busy ignored");
        peek(3'd0, 8'h04, "R9 done after erase");
        wr(3'd1, 8'h11);
        peek(3'd4, 8'hFF, "R8 erased cell reads FF");

        // R6: chip erase rules
        wr(3'd1, 8'h44);
        peek(3'd0, 8'h02, "R6 chip erase refused from internal code");
        fetch_src = 2'b10; lock_lvl0 = 3'd4;
        wr(3'd1, 8'h44);
        peek(3'd0, 8'h02, "R6 chip erase refused at level 4");
        lock_lvl0 = 3'd3; lock_lvl1 = 3'd1;
        wr(3'd1, 8'h44);
        measure(n, p);
        chk(n == 20, "R7 chip erase length", n, 20);
        chk(p == 1, "R6 lock clear pulse once", p, 1);
        lock_lvl0 = 3'd0; lock_lvl1 = 3'd0;
        wr(3'd5, 8'h42); wr(3'd1, 8'h11);
        peek(3'd4, 8'hFF, "R6 chip erase cleared bank0");

        // R10: unknown code
        wr(3'd1, 8'h77);
        @(negedge clk);
        chk(osc_en == 1'b0, "R10 unknown code not started", osc_en, 0);
        peek(3'd0, 8'h02, "R10 unknown code rejected");

        done_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done_run = 1;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule